// File: doc/BRIEF.md
# Prioritised Interrupt Source with Acknowledge Chain

This block is a bus interrupt source. A local trigger pulse arms a request. The request is shown as a low level on one of seven active-low interrupt request lines, and a configuration input picks which line. Level 7 is the most urgent and level 1 the least.

When a handler acknowledges an interrupt, the block sits in a daisy chain of acknowledge signals. The chain both marks that an acknowledge cycle is running and picks which source answers. The block answers only when three things hold: the chain input reaches it, the acknowledged level code matches its own level, and its request is still armed. When it answers, it puts an 8-bit status/ID word on the data bus, asserts transfer acknowledge one clock later, and drops its request. If it does not answer, it passes the chain on to the next slot.

There is no address decode. Chain position and the level match alone decide which source answers.

Top module: `irq_chain_responder`

## Requirements
- R1: While reset is held, and just after it is released, every request line, chain output and transfer acknowledge is high (negated), and the data drive enable is 0.
- R2: A trigger sampled at a clock edge pulls request line bit k-1 low from that edge on, where k (1..7) is the configured level. No other line is pulled low. A configured level of 0 arms nothing.
- R3: A trigger that arrives while a request is already armed is merged into it. One acknowledge cycle clears the request, and the line stays high afterwards.
- R4: If chain input and data strobe are both sampled low, and the level code differs or no request is armed, then chain output goes low at that edge. It stays low while chain input stays low. It goes high at the first edge that samples chain input high.
- R5: If chain input and data strobe are sampled low, the level code equals the configured level, and a request is armed, then chain output stays high. Drive enable goes to 1 at that edge.
- R6: Transfer acknowledge goes low exactly one edge after drive enable rises, and never while the data is not being driven.
- R7: The request line returns high at the same edge where drive enable rises.
- R8: Once the data strobe is sampled high during an answer, transfer acknowledge goes high and drive enable goes to 0 at that edge.
- R9: While chain input is high, the block neither answers nor passes the chain on, whatever the strobe and level code are.
- R10: The status/ID value is captured at the edge where the block answers. Later changes to the status/ID input do not alter the data being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Local interrupt trigger, one-clock pulse |
| cfg_level | input | 3 | Configured request level, 1..7, 0 disables |
| status_id | input | 8 | Status/ID word returned on acknowledge |
| ack_level | input | 3 | Level code of the running acknowledge cycle |
| ackin_n | input | 1 | Acknowledge chain input, active low |
| ds_n | input | 1 | Data strobe, active low |
| irq_n | output | 7 | Request lines, bit k-1 is level k, active low |
| ackout_n | output | 1 | Acknowledge chain output, active low |
| dtack_n | output | 1 | Transfer acknowledge, active low |
| data_out | output | 8 | Status/ID data driven on answer |
| data_oe | output | 1 | Data drive enable |

## Verification
Every output comes from a register. Request lines, chain output and drive enable therefore change at the first edge that samples their cause. Transfer acknowledge lags drive enable by one further edge. Release is due at the first edge that samples the strobe high. The bench changes inputs just after a rising edge and reads the outputs one time unit after the next edge, so each check looks at the state exactly one edge after its stimulus. The acknowledge lag is checked as a separate table row.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_DRIVE = 2'd2,
        ST_ACK   = 2'd3
    } chain_state_e;

endpackage

// File: rtl/irq_line_encoder.sv
module irq_line_encoder #(
    parameter int NUM_LEVELS = 7,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  armed,
    input  logic [LVL_W-1:0]      level,
    output logic [NUM_LEVELS-1:0] lines_n
);

    // One open request line per level; level k drives bit k-1.
    for (genvar k = 1; k <= NUM_LEVELS; k++) begin : g_line
        assign lines_n[k-1] = !(armed && (level == LVL_W'(k)));
    end

endmodule

// File: rtl/irq_ack_match.sv
module irq_ack_match #(
    parameter int LVL_W = 3
) (
    input  logic             armed,
    input  logic [LVL_W-1:0] own_level,
    input  logic [LVL_W-1:0] cycle_level,
    input  logic             ackin_n,
    input  logic             ds_n,
    output logic             cycle_seen,
    output logic             selected
);

    logic level_hit;

    assign cycle_seen = !ackin_n && !ds_n;
    assign level_hit  = (own_level != '0) && (own_level == cycle_level);
    assign selected   = cycle_seen && armed && level_hit;

endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder #(
    parameter int NUM_LEVELS = 7,
    parameter int ID_W       = 8,
    parameter int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  trig,
    input  logic [LVL_W-1:0]      cfg_level,
    input  logic [ID_W-1:0]       status_id,
    input  logic [LVL_W-1:0]      ack_level,
    input  logic                  ackin_n,
    input  logic                  ds_n,
    output logic [NUM_LEVELS-1:0] irq_n,
    output logic                  ackout_n,
    output logic                  dtack_n,
    output logic [ID_W-1:0]       data_out,
    output logic                  data_oe
);

    import irq_chain_pkg::*;

    typedef struct packed {
        chain_state_e    st;
        logic            armed;
        logic [ID_W-1:0] id;
        logic            pass;
        logic            ack;
        logic            oe;
    } ctl_t;

    ctl_t s_d, s_q;
    logic cycle_seen;
    logic selected;
    logic arm_req;

    irq_ack_match #(.LVL_W(LVL_W)) u_match (
        .armed      (s_q.armed),
        .own_level  (cfg_level),
        .cycle_level(ack_level),
        .ackin_n    (ackin_n),
        .ds_n       (ds_n),
        .cycle_seen (cycle_seen),
        .selected   (selected)
    );

    irq_line_encoder #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_lines (
        .armed  (s_q.armed),
        .level  (cfg_level),
        .lines_n(irq_n)
    );

    assign arm_req = trig && (cfg_level != '0);

    always_comb begin
        s_d = s_q;
        // A trigger while armed merges into the existing request.
        s_d.armed = s_q.armed || arm_req;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cycle_seen) begin
                    if (selected) begin
                        s_d.st    = ST_DRIVE;
                        s_d.oe    = 1'b1;
                        s_d.id    = status_id;
                        s_d.armed = arm_req;
                    end else begin
                        s_d.st   = ST_PASS;
                        s_d.pass = 1'b1;
                    end
                end
            end
            ST_PASS: begin
                if (ackin_n) begin
                    s_d.st   = ST_IDLE;
                    s_d.pass = 1'b0;
                end
            end
            ST_DRIVE: begin
                if (ds_n) begin
                    s_d.st = ST_IDLE;
                    s_d.oe = 1'b0;
                end else begin
                    s_d.st  = ST_ACK;
                    s_d.ack = 1'b1;
                end
            end
            ST_ACK: begin
                if (ds_n) begin
                    s_d.st  = ST_IDLE;
                    s_d.ack = 1'b0;
                    s_d.oe  = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, armed: 1'b0, id: '0, pass: 1'b0, ack: 1'b0, oe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign ackout_n = !s_q.pass;
    assign dtack_n  = !s_q.ack;
    assign data_oe  = s_q.oe;
    assign data_out = s_q.id;

endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker #(
    parameter int NUM_LEVELS = 7,
    parameter int ID_W       = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ackin_n,
    input logic                  ds_n,
    input logic [NUM_LEVELS-1:0] irq_n,
    input logic                  ackout_n,
    input logic                  dtack_n,
    input logic [ID_W-1:0]       data_out,
    input logic                  data_oe
);

    // R2: at most one request line active at a time
    assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~irq_n));

    // R4: chain output only follows a low chain input
    assert_pass_needs_ackin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ackout_n) |-> $past(!ackin_n));

    // R5: never pass the chain on while answering
    assert_no_pass_when_driving_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ackout_n && data_oe));

    // R6: acknowledge only after data has been driven for a cycle
    assert_dtack_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> $past(data_oe));

    // R6: acknowledge never without data drive
    assert_dtack_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> data_oe);

    // R8: strobe release frees the bus at the next edge
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && ds_n) |=> (dtack_n && !data_oe));

    // R10: driven data stays stable while acknowledged
    assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && $past(!dtack_n)) |-> $stable(data_out));

endmodule

bind irq_chain_responder irq_chain_checker #(.NUM_LEVELS(NUM_LEVELS), .ID_W(ID_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ackin_n (ackin_n),
    .ds_n    (ds_n),
    .irq_n   (irq_n),
    .ackout_n(ackout_n),
    .dtack_n (dtack_n),
    .data_out(data_out),
    .data_oe (data_oe)
);

// File: tb/irq_chain_responder_test.sv
module irq_chain_responder_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig = 1'b0;
    logic [2:0] cfg_level = 3'd3;
    logic [7:0] status_id = 8'hA5;
    logic [2:0] ack_level = 3'd0;
    logic       ackin_n = 1'b1;
    logic       ds_n = 1'b1;
    logic [6:0] irq_n;
    logic       ackout_n;
    logic       dtack_n;
    logic [7:0] data_out;
    logic       data_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_chain_responder uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_level(cfg_level),
        .status_id(status_id), .ack_level(ack_level), .ackin_n(ackin_n),
        .ds_n(ds_n), .irq_n(irq_n), .ackout_n(ackout_n), .dtack_n(dtack_n),
        .data_out(data_out), .data_oe(data_oe)
    );

    // trig, ackin_n, ds_n, ack_level -> expected irq_n, ackout_n, dtack_n, data_oe
    typedef struct packed {
        logic       trig;
        logic       ackin_n;
        logic       ds_n;
        logic [2:0] lvl;
        logic [6:0] e_irq;
        logic       e_ackout;
        logic       e_dtack;
        logic       e_oe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 1'b1, 3'd0, 7'h7F, 1'b1, 1'b1, 1'b0}, // idle after reset R1
        '{1'b1, 1'b1, 1'b1, 3'd0, 7'h7B, 1'b1, 1'b1, 1'b0}, // arm level 3 R2
        '{1'b1, 1'b1, 1'b1, 3'd0, 7'h7B, 1'b1, 1'b1, 1'b0}, // merged trigger R3
        '{1'b0, 1'b0, 1'b0, 3'd5, 7'h7B, 1'b0, 1'b1, 1'b0}, // mismatch passes R4
        '{1'b0, 1'b0, 1'b0, 3'd5, 7'h7B, 1'b0, 1'b1, 1'b0}, // held R4
        '{1'b0, 1'b1, 1'b1, 3'd0, 7'h7B, 1'b1, 1'b1, 1'b0}, // released R4
        '{1'b0, 1'b0, 1'b0, 3'd3, 7'h7F, 1'b1, 1'b1, 1'b1}, // answer R5 R7
        '{1'b0, 1'b0, 1'b0, 3'd3, 7'h7F, 1'b1, 1'b0, 1'b1}, // dtack lag R6
        '{1'b0, 1'b0, 1'b0, 3'd3, 7'h7F, 1'b1, 1'b0, 1'b1}, // held R6
        '{1'b0, 1'b1, 1'b1, 3'd0, 7'h7F, 1'b1, 1'b1, 1'b0}, // strobe release R8
        '{1'b0, 1'b0, 1'b0, 3'd3, 7'h7F, 1'b0, 1'b1, 1'b0}, // nothing armed R4
        '{1'b0, 1'b1, 1'b1, 3'd0, 7'h7F, 1'b1, 1'b1, 1'b0}, // released R4
        '{1'b0, 1'b1, 1'b1, 3'd0, 7'h7F, 1'b1, 1'b1, 1'b0}  // single request only R3
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_outs(input string tag, input logic [6:0] e_irq, input logic e_ao,
                              input logic e_dt, input logic e_oe);
        check(tag, {6'd0, irq_n, ackout_n, dtack_n, data_oe}, {6'd0, e_irq, e_ao, e_dt, e_oe});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trig = 1'b0; ackin_n = 1'b1; ds_n = 1'b1; ack_level = 3'd0;
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: state during reset
        #1;
        check_outs("R1 in reset", 7'h7F, 1'b1, 1'b1, 1'b0);
        step();
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            trig = VEC[i].trig;
            ackin_n = VEC[i].ackin_n;
            ds_n = VEC[i].ds_n;
            ack_level = VEC[i].lvl;
            step();
            check_outs($sformatf("table row %0d R2-R8", i), VEC[i].e_irq, VEC[i].e_ackout,
                       VEC[i].e_dtack, VEC[i].e_oe);
        end
        trig = 1'b0;

        // R2: level 7 uses bit 6
        do_reset();
        cfg_level = 3'd7;
        trig = 1'b1;
        step();
        trig = 1'b0;
        check_outs("R2 level 7 line", 7'h3F, 1'b1, 1'b1, 1'b0);

        // R9: chain input high, strobe low, matching level: no action
        ds_n = 1'b0; ack_level = 3'd7;
        step();
        check_outs("R9 ackin high", 7'h3F, 1'b1, 1'b1, 1'b0);
        step();
        check_outs("R9 ackin high again", 7'h3F, 1'b1, 1'b1, 1'b0);

        // R10: status captured at answer edge
        status_id = 8'h3C;
        ackin_n = 1'b0;
        step();
        status_id = 8'hFF;
        check_outs("R5 answer level 7", 7'h7F, 1'b1, 1'b1, 1'b1);
        check("R10 data at answer", {8'd0, data_out}, 16'h003C);
        step();
        check("R10 data after id change", {8'd0, data_out}, 16'h003C);
        check_outs("R6 dtack level 7", 7'h7F, 1'b1, 1'b0, 1'b1);
        ds_n = 1'b1; ackin_n = 1'b1;
        step();
        check_outs("R8 release level 7", 7'h7F, 1'b1, 1'b1, 1'b0);

        // R2: configured level 0 arms nothing
        do_reset();
        cfg_level = 3'd0;
        trig = 1'b1;
        step();
        trig = 1'b0;
        check_outs("R2 level 0 disabled", 7'h7F, 1'b1, 1'b1, 1'b0);

        // R1: reset after activity clears everything
        cfg_level = 3'd1;
        trig = 1'b1;
        step();
        trig = 1'b0;
        check_outs("R2 level 1 line", 7'h7E, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check_outs("R1 async reset", 7'h7F, 1'b1, 1'b1, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check_outs("R1 after reset", 7'h7F, 1'b1, 1'b1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule